// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the control port of a two-channel line interface device. An external controller reaches it over four wires: an active-low chip select, a serial clock, a serial data input and a serial data output. Each transaction begins with a command header carrying a read/write flag and a register address. Eight data bits follow the header. A write stores the data bits into a small register file. A read returns the addressed register on the serial output.

The serial pins are oversampled by the block's own system clock. Chip select, serial clock and serial data pass through synchronizer chains of equal length, so their relative timing is kept. A shift engine counts the sampled rising edges of the serial clock and assembles the header and the data. On reads it moves the serial output on sampled falling edges.

Two registers in the file act as per-channel command registers. Their bits are decoded into a registered line-mode select and a registered loop-back mode for each channel. These decoded values are the only control outputs of the block.

Top module: `sctl_serial_port`

## Requirements
- R1: After the synchronous reset, every register reads 0, each channel reports line mode DS3 (code 0) and loop-back none (code 0), and `sdo` and `sdo_oe` are 0.
- R2: Frame bit 0 (first sampled) is the read/write flag, where 0 means write. Frame bits 1 to 4 carry the address, A0 first. Frame bits 8 to 15 carry the data, D0 first. After the sixteenth rising edge of a write, the data is committed to the addressed register.
- R3: When the flag is 1 (read), `sdo` presents bit k of the addressed register after the falling `sclk` edge that follows frame bit 7+k. `sdo_oe` is 1 while these bits are driven.
- R4: Frame bits 5, 6 and 7 are sampled and discarded. Their values change neither the address nor the data of the transaction.
- R5: If chip select is released before the sixteenth rising edge, no register changes. The next transaction starts again from frame bit 0.
- R6: Bit 2 of a channel command register set to 1 gives line mode E3 (code 2), whatever the value of bit 3.
- R7: With bit 2 at 0, bit 3 selects the line mode: 0 gives DS3 (code 0) and 1 gives STS-1 (code 1).
- R8: Command bits {1,0} select the loop-back code: 00 gives none (0), 10 gives analog (1), 11 gives digital (2) and 01 gives remote (3).
- R9: `sdo` and `sdo_oe` are 0 while chip select is high and throughout write transactions.
- R10: Channel n takes its command from address 1+n and reports on bits [2n+1:2n] of `ch_mode` and `ch_lpbk`. Writes to any other address leave the channel outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| sdo | output | 1 | Serial data out, updated on falling `sclk` |
| sdo_oe | output | 1 | High while `sdo` carries read data |
| ch_mode | output | 2*NCH | Per-channel line mode: 0 DS3, 1 STS-1, 2 E3 |
| ch_lpbk | output | 2*NCH | Per-channel loop-back: 0 none, 1 analog, 2 digital, 3 remote |

## Verification
The hardest situation to reach is a chip select release partway through a frame. It must leave both the register file and the decoded channel outputs untouched, and it must also leave no residue in the bit counter that would shift the next frame. The stimulus truncates writes to the channel registers at several bit counts, including one edge short of the commit. Each truncated write is followed at once by a full read of the same register and a check of the channel outputs. A wrong frame alignment then shows up as a wrong address or as rotated data. The stimulus also fills the discarded header bits with random values, so that a decoder reading them would pick up a wrong address.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  // Decoded line mode per channel
  typedef enum logic [1:0] {
    LM_DS3  = 2'd0,
    LM_STS1 = 2'd1,
    LM_E3   = 2'd2
  } line_mode_e;

  // Decoded loop-back selection per channel
  typedef enum logic [1:0] {
    LB_NONE    = 2'd0,
    LB_ANALOG  = 2'd1,
    LB_DIGITAL = 2'd2,
    LB_REMOTE  = 2'd3
  } lpbk_e;

  // Bit positions inside a channel command register
  localparam int CFG_RLB  = 0;
  localparam int CFG_LLB  = 1;
  localparam int CFG_E3   = 2;
  localparam int CFG_STS1 = 3;
endpackage

// File: rtl/sctl_sync_edge.sv
module sctl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic sdi_s
);
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] sd_q;
  logic              sck_d;

  // Equal-length chains keep the pin-to-pin ordering intact
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0;
      cs_q  <= '1;
      sd_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sclk};
      cs_q  <= {cs_q[STAGES-2:0], cs_n};
      sd_q  <= {sd_q[STAGES-2:0], sdi};
      sck_d <= sck_q[STAGES-1];
    end
  end

  assign sclk_rise = sck_q[STAGES-1] & ~sck_d;
  assign sclk_fall = ~sck_q[STAGES-1] & sck_d;
  assign cs_act    = ~cs_q[STAGES-1];
  assign sdi_s     = sd_q[STAGES-1];
endmodule

// File: rtl/sctl_shift_engine.sv
module sctl_shift_engine #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int HDR_BITS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdi,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic          rd_flag,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int TOTAL = HDR_BITS + DW;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int DIW   = $clog2(DW);

  logic [CW-1:0] bitcnt;
  logic [CW-1:0] didx;
  logic [DW-1:0] data_sh;

  assign didx = bitcnt - CW'(HDR_BITS);

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      // Idle or aborted frame: everything returns to a clean start
      bitcnt  <= '0;
      rd_flag <= 1'b0;
      addr    <= '0;
      data_sh <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (sclk_rise && (bitcnt < CW'(TOTAL))) begin
        bitcnt <= bitcnt + CW'(1);
        if (bitcnt == '0) begin
          rd_flag <= sdi;
        end else if (bitcnt <= CW'(AW)) begin
          addr <= {sdi, addr[AW-1:1]};
        end else if (bitcnt >= CW'(HDR_BITS)) begin
          data_sh <= {sdi, data_sh[DW-1:1]};
          if ((bitcnt == CW'(TOTAL - 1)) && !rd_flag) begin
            wr_en   <= 1'b1;
            wr_data <= {sdi, data_sh[DW-1:1]};
          end
        end
      end
      if (sclk_fall && rd_flag && (bitcnt >= CW'(HDR_BITS)) && (bitcnt < CW'(TOTAL))) begin
        sdo    <= rd_data[didx[DIW-1:0]];
        sdo_oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile #(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int NCH     = 2,
  parameter int CH_BASE = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wr_data,
  output logic [DW-1:0]           rd_data,
  output logic [NCH-1:0][DW-1:0]  ch_cfg
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) mem[addr] <= wr_data;
      rd_data <= mem[addr];
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_tap
    assign ch_cfg[n] = mem[CH_BASE + n];
  end
endmodule

// File: rtl/sctl_chan_decode.sv
module sctl_chan_decode #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg,
  output logic [1:0]    mode,
  output logic [1:0]    lpbk
);
  import sctl_pkg::*;

  line_mode_e mode_nx;
  lpbk_e      lpbk_nx;

  always_comb begin
    if (cfg[CFG_E3])        mode_nx = LM_E3;
    else if (cfg[CFG_STS1]) mode_nx = LM_STS1;
    else                    mode_nx = LM_DS3;
    case ({cfg[CFG_LLB], cfg[CFG_RLB]})
      2'b10:   lpbk_nx = LB_ANALOG;
      2'b11:   lpbk_nx = LB_DIGITAL;
      2'b01:   lpbk_nx = LB_REMOTE;
      default: lpbk_nx = LB_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= LM_DS3;
      lpbk <= LB_NONE;
    end else begin
      mode <= mode_nx;
      lpbk <= lpbk_nx;
    end
  end
endmodule

// File: rtl/sctl_serial_port.sv
module sctl_serial_port #(
  parameter int NCH         = 2,
  parameter int AW          = 4,
  parameter int DW          = 8,
  parameter int HDR_BITS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CH_BASE     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [2*NCH-1:0] ch_mode,
  output logic [2*NCH-1:0] ch_lpbk
);
  logic                   sclk_rise;
  logic                   sclk_fall;
  logic                   cs_act;
  logic                   sdi_s;
  logic [AW-1:0]          addr;
  logic                   rd_flag;
  logic                   wr_en;
  logic [DW-1:0]          wr_data;
  logic [DW-1:0]          rd_data;
  logic [NCH-1:0][DW-1:0] ch_cfg;

  sctl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .sdi_s(sdi_s)
  );

  sctl_shift_engine #(.AW(AW), .DW(DW), .HDR_BITS(HDR_BITS)) u_eng (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi(sdi_s), .rd_data(rd_data), .addr(addr),
    .rd_flag(rd_flag), .wr_en(wr_en), .wr_data(wr_data), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  sctl_regfile #(.AW(AW), .DW(DW), .NCH(NCH), .CH_BASE(CH_BASE)) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ch_cfg(ch_cfg)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    sctl_chan_decode #(.DW(DW)) u_dec (
      .clk(clk), .rst(rst), .cfg(ch_cfg[n]),
      .mode(ch_mode[2*n +: 2]), .lpbk(ch_lpbk[2*n +: 2])
    );
  end
endmodule

// File: rtl/sctl_serial_port_chk.sv
module sctl_serial_port_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_act,
  input logic             wr_en,
  input logic             rd_flag,
  input logic             sdo,
  input logic             sdo_oe,
  input logic [2*NCH-1:0] ch_mode,
  input logic [2*NCH-1:0] ch_lpbk
);
  // R9: output quiet once chip select is seen released
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (sdo == 1'b0 && !sdo_oe));

  // R3: output enable only within read frames
  p_oe_read_only_r3: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> rd_flag);

  // R2: a commit is a single-cycle pulse and never belongs to a read
  p_single_commit_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  p_commit_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rd_flag);

  // R5: without a commit the channel outputs hold
  p_outputs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |=> ($stable(ch_mode) && $stable(ch_lpbk)));

  // R6: the line mode code 3 is never produced
  for (genvar n = 0; n < NCH; n++) begin : g_mode
    p_mode_legal_r6: assert property (@(posedge clk) disable iff (rst)
      ch_mode[2*n +: 2] != 2'b11);
  end
endmodule

bind sctl_serial_port sctl_serial_port_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .wr_en(wr_en), .rd_flag(rd_flag),
  .sdo(sdo), .sdo_oe(sdo_oe), .ch_mode(ch_mode), .ch_lpbk(ch_lpbk)
);

// File: tb/sctl_serial_port_tb.sv
module sctl_serial_port_tb;
  localparam int NCH = 2;
  localparam int HP  = 8;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [2*NCH-1:0] ch_mode, ch_lpbk;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #10 clk = ~clk;

  sctl_serial_port u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .ch_mode(ch_mode), .ch_lpbk(ch_lpbk)
  );

  function automatic int exp_mode(input logic [7:0] c);
    if (c[2]) return 2;
    return c[3] ? 1 : 0;
  endfunction

  function automatic int exp_lpbk(input logic [7:0] c);
    case ({c[1], c[0]})
      2'b10:   return 1;
      2'b11:   return 2;
      2'b01:   return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit rw, input logic [3:0] a, input logic [2:0] junk,
                      input logic [7:0] d, input int nbits, output logic [7:0] rd);
    logic [15:0] frame;
    frame = {d, junk, a, rw};
    rd = '0;
    @(negedge clk);
    cs_n = 1'b0;
    hold(HP);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi  = frame[i];
      hold(HP);
      if (i >= 8) begin
        if (rw) begin
          rd[i-8] = sdo;
          check(sdo_oe == 1'b1, "R3 sdo_oe during read data", int'(sdo_oe), 1);
        end else begin
          check(sdo == 1'b0 && sdo_oe == 1'b0, "R9 sdo quiet in write", int'({sdo_oe, sdo}), 0);
        end
      end
      sclk = 1'b1;
      hold(HP);
    end
    sclk = 1'b0;
    hold(HP);
    cs_n = 1'b1;
    hold(HP);
    if (!rw && nbits == 16) model[a] = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [2:0] junk);
    logic [7:0] unused;
    xfer(1'b0, a, junk, d, 16, unused);
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [2:0] junk, input string tag);
    logic [7:0] got;
    xfer(1'b1, a, junk, 8'hA5, 16, got);
    check(got == model[a], tag, int'(got), int'(model[a]));
  endtask

  task automatic chan_check(input string tag);
    for (int n = 0; n < NCH; n++) begin
      check(int'(ch_mode[2*n +: 2]) == exp_mode(model[1+n]), {tag, " mode"},
            int'(ch_mode[2*n +: 2]), exp_mode(model[1+n]));
      check(int'(ch_lpbk[2*n +: 2]) == exp_lpbk(model[1+n]), {tag, " lpbk"},
            int'(ch_lpbk[2*n +: 2]), exp_lpbk(model[1+n]));
    end
  endtask

  initial begin
    logic [7:0] dummy;
    int seed_init;
    seed_init = $urandom(32'h5EED_0042);
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    hold(5);
    rst = 1'b0;
    hold(3);

    // R1 reset state
    check(ch_mode == '0, "R1 reset ch_mode", int'(ch_mode), 0);
    check(ch_lpbk == '0, "R1 reset ch_lpbk", int'(ch_lpbk), 0);
    check(sdo == 1'b0 && sdo_oe == 1'b0, "R1 R9 reset sdo", int'({sdo_oe, sdo}), 0);
    rd_check(4'd9, 3'd0, "R1 reset register reads 0");

    // R6 E3 wins over bit 3
    wr(4'd1, 8'h04, 3'd0); chan_check("R6 E3 bit3 low");
    wr(4'd1, 8'h0C, 3'd0); chan_check("R6 E3 bit3 high");
    // R7 DS3 / STS-1
    wr(4'd1, 8'h08, 3'd0); chan_check("R7 STS-1");
    wr(4'd1, 8'h00, 3'd0); chan_check("R7 DS3");
    // R8 loop-back codes on channel 1, R10 channel 0 untouched
    wr(4'd2, 8'h02, 3'd0); chan_check("R8 R10 analog");
    wr(4'd2, 8'h03, 3'd0); chan_check("R8 R10 digital");
    wr(4'd2, 8'h01, 3'd0); chan_check("R8 R10 remote");
    wr(4'd2, 8'h00, 3'd0); chan_check("R8 R10 none");
    wr(4'd2, 8'h0B, 3'd0); chan_check("R8 STS-1 with digital");
    rd_check(4'd2, 3'd0, "R2 R3 readback channel reg");

    // R10 other addresses leave outputs alone
    wr(4'd0, 8'hFF, 3'd0); wr(4'd3, 8'hFF, 3'd0);
    chan_check("R10 neighbour writes");

    // R4 discarded header bits
    wr(4'd5, 8'h5A, 3'b111);
    rd_check(4'd5, 3'b101, "R4 junk header bits");

    // R5 aborts at several points
    xfer(1'b0, 4'd1, 3'd0, 8'hFF, 15, dummy);
    chan_check("R5 abort one short");
    rd_check(4'd1, 3'd0, "R5 readback after abort15");
    xfer(1'b0, 4'd1, 3'd0, 8'hFF, 3, dummy);
    rd_check(4'd1, 3'd0, "R5 readback after abort3");
    xfer(1'b1, 4'd5, 3'd0, 8'h00, 11, dummy);
    check(sdo == 1'b0 && sdo_oe == 1'b0, "R9 idle after read abort", int'({sdo_oe, sdo}), 0);
    wr(4'd7, 8'hC3, 3'd0);
    rd_check(4'd7, 3'd0, "R5 clean frame after aborts");

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic [2:0] j;
      a = 4'($urandom);
      d = 8'($urandom);
      j = 3'($urandom);
      if ($urandom % 2 == 0) begin
        wr(a, d, j);
        chan_check("R2 R6 R7 R8 random write");
      end else begin
        rd_check(a, j, "R2 R3 random read");
      end
      check(sdo == 1'b0 && sdo_oe == 1'b0, "R9 idle between frames", int'({sdo_oe, sdo}), 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule